// File: doc/BRIEF.md
# Latched Error Event Counter

This block counts error events for one tributary and lets a microprocessor read the total without tearing it. Once per received path overhead byte the receive side presents the byte with a valid strobe. When the byte's remote-error flag is set, the block adds one to an 11-bit live counter, sets a sticky event interrupt and, if enabled, sends a one-cycle remote-error indication toward the transmit side.

Software reads the count in three steps. It first writes any value to either of the two snapshot addresses. That write copies the live count into a holding register and clears the live counter in the same clock. Software then waits at least three byte-clock cycles and reads the low and high bytes. When the live count passes its 11-bit maximum it wraps to zero and sets a sticky overflow interrupt. Interrupt bits are cleared by writing ones to them.

Top module: `errcnt_latch`

## Requirements
- R1: An event is a cycle with `ev_valid` high and byte bit 3 high, with bits numbered 1 to 8 from the MSB (`ev_byte[5]`). The other seven bits and bytes without `ev_valid` never change the count.
- R2: Each event adds exactly one to the live count. In a cycle with no event and no latching write, the count holds its value.
- R3: An event while the count is 2047 makes the count 0 and sets the overflow interrupt (status bit 1, port `irq_overflow`). An event while the count is below 2047 does not set it.
- R4: A write of any data to address 0 or address 1 copies the live count into the holding register and clears the live count. The held value can be read from the next cycle on and does not change until the next such write.
- R5: A read of address 0 returns held bits 7:0. A read of address 1 returns held bits 10:8 in data bits 2:0, with zeros above them.
- R6: If an event arrives in the same cycle as a latching write, the held value is the count before that event and the live count restarts at 1.
- R7: Each event sets the sticky event interrupt (status bit 0 at address 2, port `irq_event`). The bit stays set until software clears it.
- R8: Writing 1 to a status bit at address 2 clears it, and writing 0 leaves it unchanged. If an interrupt source fires in the same cycle as the clear, the bit stays set.
- R9: `tx_rei` is high for the one cycle after each event while the enable bit (address 3, bit 0) is 1. While that bit is 0, `tx_rei` stays low.
- R10: After reset the live count, held value and both interrupts are 0, and the transmit enable is 1.
- R11: Writes to addresses 2 and 3 neither latch nor clear the count. Address 3 reads back the enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Overhead byte present this cycle |
| ev_byte | input | 8 | Received path overhead byte |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the registers |
| irq_event | output | 1 | Sticky event interrupt |
| irq_overflow | output | 1 | Sticky overflow interrupt |
| tx_rei | output | 1 | Remote-error indication toward the transmitter |

## Verification
The embedded assertions check the following on every cycle:
- the counter's single-step, hold, wrap and clear-with-restart transitions;
- the capture of the pre-clear count by a latching write;
- that the event interrupt stays set unless a clear is written;
- that the transmit indication stays low while it is disabled.

Only the bench's scenarios can show the rest:
- the byte layout of the held value across the two addresses;
- that non-flag bits and invalid bytes are ignored;
- that the full 2048-event wrap raises overflow at the right event and not before;
- that writes to the other addresses leave the count alone.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    typedef enum logic [1:0] {
        ADR_SNAP_LO = 2'd0,
        ADR_SNAP_HI = 2'd1,
        ADR_IRQ     = 2'd2,
        ADR_CFG     = 2'd3
    } adr_e;

    localparam int IRQ_EV_BIT    = 0;
    localparam int IRQ_OV_BIT    = 1;
    localparam int CFG_TX_EN_BIT = 0;

endpackage

// File: rtl/evcnt_detect.sv
module evcnt_detect #(
    parameter int DATA_W = 8,
    parameter int EV_BIT = 5
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] byte_in,
    output logic              hit
);
    // The remaining bits of the byte belong to other overhead functions.
    logic unused_bits;

    always_comb begin
        hit         = valid & byte_in[EV_BIT];
        unused_bits = ^byte_in;
    end
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        if (clr) begin
            // An event coinciding with the clear is kept in the new count.
            st_d.cnt = inc ? CNT_ONE : '0;
        end else if (inc) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.cnt = '0;
                ovf      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && st_q.cnt != CNT_MAX) |=> st_q.cnt == $past(st_q.cnt) + CNT_ONE);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(st_q.cnt));
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> st_q.cnt == '0);
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == ($past(inc) ? CNT_ONE : '0));
endmodule

// File: rtl/evcnt_regs.sv
module evcnt_regs
    import evcnt_pkg::*;
#(
    parameter int CNT_W  = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_live,
    input  logic              ev_hit,
    input  logic              ovf,
    output logic              latch,
    output logic              irq_ev,
    output logic              irq_ov,
    output logic              tx_en
);
    localparam int EXT_W = 2 * DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] snap;
        logic             irq_ev;
        logic             irq_ov;
        logic             tx_en;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_irq, wr_cfg;
    logic [EXT_W-1:0] snap_ext;

    always_comb begin
        wr_irq = bus_sel && bus_wr && (adr_e'(bus_addr) == ADR_IRQ);
        wr_cfg = bus_sel && bus_wr && (adr_e'(bus_addr) == ADR_CFG);
        latch  = bus_sel && bus_wr &&
                 ((adr_e'(bus_addr) == ADR_SNAP_LO) || (adr_e'(bus_addr) == ADR_SNAP_HI));

        st_d = st_q;
        if (latch) st_d.snap = cnt_live;
        // Set has priority over a simultaneous clear.
        st_d.irq_ev = (st_q.irq_ev & ~(wr_irq & bus_wdata[IRQ_EV_BIT])) | ev_hit;
        st_d.irq_ov = (st_q.irq_ov & ~(wr_irq & bus_wdata[IRQ_OV_BIT])) | ovf;
        if (wr_cfg) st_d.tx_en = bus_wdata[CFG_TX_EN_BIT];

        snap_ext  = EXT_W'(st_q.snap);
        bus_rdata = '0;
        unique case (adr_e'(bus_addr))
            ADR_SNAP_LO: bus_rdata = snap_ext[DATA_W-1:0];
            ADR_SNAP_HI: bus_rdata = snap_ext[EXT_W-1:DATA_W];
            ADR_IRQ: begin
                bus_rdata[IRQ_EV_BIT] = st_q.irq_ev;
                bus_rdata[IRQ_OV_BIT] = st_q.irq_ov;
            end
            ADR_CFG: bus_rdata[CFG_TX_EN_BIT] = st_q.tx_en;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.tx_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_ev = st_q.irq_ev;
    assign irq_ov = st_q.irq_ov;
    assign tx_en  = st_q.tx_en;

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> st_q.snap == $past(cnt_live));
    a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(st_q.snap));
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit |=> st_q.irq_ev);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq_ev && !(wr_irq && bus_wdata[IRQ_EV_BIT])) |=> st_q.irq_ev);
endmodule

// File: rtl/errcnt_latch.sv
module errcnt_latch #(
    parameter int CNT_W  = 11,
    parameter int DATA_W = 8,
    parameter int EV_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [DATA_W-1:0] ev_byte,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_event,
    output logic              irq_overflow,
    output logic              tx_rei
);
    typedef struct packed {
        logic tx;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             hit, latch, ovf, tx_en;
    logic [CNT_W-1:0] cnt;

    evcnt_detect #(.DATA_W(DATA_W), .EV_BIT(EV_BIT)) u_detect (
        .valid   (ev_valid),
        .byte_in (ev_byte),
        .hit     (hit)
    );

    evcnt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hit),
        .clr   (latch),
        .cnt   (cnt),
        .ovf   (ovf)
    );

    evcnt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_live  (cnt),
        .ev_hit    (hit),
        .ovf       (ovf),
        .latch     (latch),
        .irq_ev    (irq_event),
        .irq_ov    (irq_overflow),
        .tx_en     (tx_en)
    );

    always_comb begin
        st_d    = st_q;
        st_d.tx = hit & tx_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_rei = st_q.tx;

    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !st_q.tx);
    a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && tx_en) |=> st_q.tx);
endmodule

// File: tb/errcnt_latch_bench.sv
module errcnt_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [7:0] ev_byte = 8'h00;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_event, irq_overflow, tx_rei;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    errcnt_latch u_errcnt_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_valid     (ev_valid),
        .ev_byte      (ev_byte),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_event    (irq_event),
        .irq_overflow (irq_overflow),
        .tx_rei       (tx_rei)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = int'(bus_rdata);
        bus_sel = 1'b0;
    endtask

    task automatic send(input int n, input logic [7:0] b, input logic v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev_valid = v; ev_byte = b;
        end
        @(negedge clk);
        ev_valid = 1'b0; ev_byte = 8'h00;
    endtask

    task automatic read_snap(output int v);
        int lo, hi;
        bus_read(2'd0, lo);
        bus_read(2'd1, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic latch_count(input logic [1:0] a, output int v);
        bus_write(a, 8'h5A);
        repeat (3) @(negedge clk);
        read_snap(v);
    endtask

    task automatic t_reset();
        int v;
        bus_read(2'd0, v); chk("R10 snap lo", v, 0);
        bus_read(2'd1, v); chk("R10 snap hi", v, 0);
        bus_read(2'd2, v); chk("R10 status", v, 0);
        bus_read(2'd3, v); chk("R10 enable", v, 1);
        chk("R10 irq ports", int'({irq_event, irq_overflow, tx_rei}), 0);
        latch_count(2'd0, v); chk("R10 live count", v, 0);
    endtask

    task automatic t_burst();
        int v;
        send(5, 8'h20, 1'b1);
        send(3, 8'hDF, 1'b1);          // R1: every bit except the flag
        send(4, 8'h20, 1'b0);          // R1: flag without valid
        latch_count(2'd0, v); chk("R1 R2 burst count", v, 5);
        chk("R7 irq_event", int'(irq_event), 1);
        latch_count(2'd1, v); chk("R4 cleared after latch", v, 0);
        send(7, 8'hFF, 1'b1);
        read_snap(v);          chk("R4 snapshot stable", v, 0);
        latch_count(2'd1, v); chk("R2 count 7", v, 7);
    endtask

    task automatic t_layout();
        int lo, hi, v;
        send(1000, 8'h20, 1'b1);
        bus_write(2'd1, 8'h00);
        repeat (3) @(negedge clk);
        bus_read(2'd0, lo); chk("R5 low byte", lo, 1000 & 8'hFF);
        bus_read(2'd1, hi); chk("R5 high byte", hi, 1000 >> 8);
        latch_count(2'd0, v); chk("R4 cleared", v, 0);
    endtask

    task automatic t_wrap();
        int v;
        bus_write(2'd2, 8'h03);
        bus_read(2'd2, v); chk("R8 write one clears", v, 0);
        send(2047, 8'h20, 1'b1);
        chk("R3 no overflow at 2047", int'(irq_overflow), 0);
        send(1, 8'h20, 1'b1);
        chk("R3 overflow at 2048", int'(irq_overflow), 1);
        send(3, 8'h20, 1'b1);
        latch_count(2'd0, v); chk("R3 wrapped count", v, 3);
        bus_read(2'd2, v); chk("R3 status bits", v, 3);
    endtask

    task automatic t_coincide();
        int v;
        send(4, 8'h20, 1'b1);
        @(negedge clk);
        ev_valid = 1'b1; ev_byte = 8'h20;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hC3;
        @(negedge clk);
        ev_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        read_snap(v); chk("R6 snapshot pre-event", v, 4);
        latch_count(2'd0, v); chk("R6 restart at 1", v, 1);
    endtask

    task automatic t_clear();
        int v;
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, v); chk("R8 write zero keeps", v, 3);
        bus_write(2'd2, 8'h02);
        bus_read(2'd2, v); chk("R8 clear overflow only", v, 1);
        @(negedge clk);
        ev_valid = 1'b1; ev_byte = 8'h20;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h01;
        @(negedge clk);
        ev_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(2'd2, v); chk("R8 set beats clear", v, 1);
        latch_count(2'd0, v); chk("R11 irq write no latch", v, 1);
    endtask

    task automatic t_tx();
        int v;
        @(negedge clk);
        ev_valid = 1'b1; ev_byte = 8'h20;
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R9 tx follows event", int'(tx_rei), 1);
        @(negedge clk);
        chk("R9 tx single cycle", int'(tx_rei), 0);
        bus_write(2'd3, 8'h00);
        bus_read(2'd3, v); chk("R11 enable reads 0", v, 0);
        @(negedge clk);
        ev_valid = 1'b1; ev_byte = 8'h20;
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R9 tx disabled", int'(tx_rei), 0);
        read_snap(v); chk("R11 cfg write keeps snapshot", v, 1);
        latch_count(2'd0, v); chk("R11 count across cfg write", v, 2);
        bus_write(2'd3, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_burst();
        t_layout();
        t_wrap();
        t_coincide();
        t_clear();
        t_tx();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule